// File: doc/BRIEF.md
# Load/Store Data Formatter

This block sits between a core's 32-bit register file and a 64-bit little-endian data bus. It converts data in both directions for the same access description. On the load side it picks the addressed bytes out of a raw bus beat and turns them into a register value, or into an even/odd register pair. On the store side it moves register data onto the correct byte lanes of the bus and builds the matching byte-enable mask. It also flags any access whose address does not suit its size.

Each access is described by a 3-bit kind code and the low address bits that select a byte lane inside the bus beat. Address generation and the memory port itself belong to neighbouring logic. All formatting is combinational. One parameter-selected output stage registers every result, so with the default setting results appear one clock after the access is presented.

Top module: `lsf_formatter`

## Requirements
- R1: Kind 0 (signed byte) loads the byte at lane `addr_lo` into `load_lo` sign-extended to 32 bits. Kind 1 (unsigned byte) zero-extends that byte.
- R2: Kind 2 (signed halfword) loads the little-endian halfword starting at lane `addr_lo` into `load_lo` sign-extended. Kind 3 (unsigned halfword) zero-extends it.
- R3: Kind 4 (fractional halfword) puts the loaded halfword in `load_lo[31:16]` and clears `load_lo[15:0]`.
- R4: Kind 5 (word) loads the word at lane `addr_lo` into `load_lo`. Kind 6 (doubleword) puts bus bits [31:0] in `load_lo` (even register) and bus bits [63:32] in `load_hi` (odd register). `load_hi` is zero for every other kind.
- R5: For kinds 0 and 1, kinds 2 and 3, and kind 5, the low 8, 16 or 32 bits of `reg_lo` appear on `mem_wdata`, starting at byte lane `addr_lo`. All other lanes are zero.
- R6: For kind 4, `reg_lo[31:16]` is written as a halfword starting at lane `addr_lo`.
- R7: For kind 6, `mem_wdata` is `{reg_hi, reg_lo}`: the even register goes to the lower word and the odd register to the upper word.
- R8: `mem_be` is 0x01, 0x03, 0x0F or 0xFF for byte, halfword (kinds 2 to 4), word and doubleword accesses, shifted left by `addr_lo`.
- R9: `misalign` is set for a halfword at an odd lane, for a word at a lane that is not a multiple of 4, and for a doubleword at any nonzero lane. A misaligned access has `mem_be` and `mem_wdata` forced to zero. Byte accesses are never misaligned.
- R10: Kind 7 is a no-access code. It gives zero load data, zero write data, zero enables and no misalign flag.
- R11: With the default output register, results and `out_valid` appear exactly one clock after `acc_valid`, and `out_valid` is low whenever no access was presented in the previous cycle. Synchronous reset clears `out_valid`, `mem_be` and `misalign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 3 | Access kind code (0 to 7) |
| addr_lo | input | 3 | Byte lane of the access within the bus beat |
| mem_rdata | input | 64 | Raw little-endian bus beat for loads |
| reg_lo | input | 32 | Store source register (even register of a pair) |
| reg_hi | input | 32 | Odd register of a pair for doubleword stores |
| out_valid | output | 1 | Results below belong to an access |
| load_lo | output | 32 | Formatted load value (even register) |
| load_hi | output | 32 | Odd register value for doubleword loads |
| mem_wdata | output | 64 | Lane-aligned store data |
| mem_be | output | 8 | Byte-enable mask, one bit per lane |
| misalign | output | 1 | Address does not suit the access size |

## Verification
Every result of this block is due one clock after `acc_valid` is sampled high. When the driver applies an access on a falling edge, it stamps the expected entry with the index of the next rising edge. The monitor samples the outputs on the following falling edge and requires the stamp of the queue head to equal the current edge count. A result that arrives early or late, or an `out_valid` with no pending entry, is reported against R11. Idle cycles are mixed into the stimulus so that `out_valid` must also drop.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  // Access kind codes; values are part of the block's interface.
  typedef enum logic [2:0] {
    ACC_SBYTE = 3'd0,
    ACC_UBYTE = 3'd1,
    ACC_SHALF = 3'd2,
    ACC_UHALF = 3'd3,
    ACC_QHALF = 3'd4,
    ACC_WORD  = 3'd5,
    ACC_DWORD = 3'd6,
    ACC_NONE  = 3'd7
  } acc_kind_e;
endpackage

// File: rtl/lsf_load_fmt.sv
module lsf_load_fmt
  import lsf_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int BUS_W = 64,
  localparam int OFS_W = $clog2(BUS_W / 8)
) (
  input  acc_kind_e          kind,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [BUS_W-1:0]   rdata,
  output logic [REG_W-1:0]   ld_lo,
  output logic [REG_W-1:0]   ld_hi
);
  // Window of the bus beat starting at the addressed lane.
  logic [REG_W-1:0] win;
  assign win = REG_W'(rdata >> {ofs, 3'b000});

  always_comb begin
    ld_lo = '0;
    ld_hi = '0;
    case (kind)
      ACC_SBYTE: ld_lo = {{(REG_W-8){win[7]}}, win[7:0]};
      ACC_UBYTE: ld_lo = {{(REG_W-8){1'b0}}, win[7:0]};
      ACC_SHALF: ld_lo = {{(REG_W-16){win[15]}}, win[15:0]};
      ACC_UHALF: ld_lo = {{(REG_W-16){1'b0}}, win[15:0]};
      ACC_QHALF: ld_lo = {win[15:0], {(REG_W-16){1'b0}}};
      ACC_WORD:  ld_lo = win;
      ACC_DWORD: begin
        ld_lo = rdata[REG_W-1:0];
        ld_hi = rdata[2*REG_W-1:REG_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsf_store_fmt.sv
module lsf_store_fmt
  import lsf_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int BUS_W = 64,
  localparam int LANES = BUS_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_kind_e          kind,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [REG_W-1:0]   reg_lo,
  input  logic [REG_W-1:0]   reg_hi,
  output logic [BUS_W-1:0]   wdata,
  output logic [LANES-1:0]   be,
  output logic               misalign
);
  logic [BUS_W-1:0] payload;
  logic [LANES-1:0] base_be;
  logic [OFS_W-1:0] align_m;

  // Per-kind payload, lane mask at lane 0, and address bits that must be zero.
  always_comb begin
    payload = '0;
    base_be = '0;
    align_m = '0;
    case (kind)
      ACC_SBYTE, ACC_UBYTE: begin
        payload = BUS_W'(reg_lo[7:0]);
        base_be = LANES'(1);
      end
      ACC_SHALF, ACC_UHALF: begin
        payload = BUS_W'(reg_lo[15:0]);
        base_be = LANES'(3);
        align_m = OFS_W'(1);
      end
      ACC_QHALF: begin
        payload = BUS_W'(reg_lo[REG_W-1:REG_W-16]);
        base_be = LANES'(3);
        align_m = OFS_W'(1);
      end
      ACC_WORD: begin
        payload = BUS_W'(reg_lo);
        base_be = LANES'(15);
        align_m = OFS_W'(3);
      end
      ACC_DWORD: begin
        payload = BUS_W'({reg_hi, reg_lo});
        base_be = '1;
        align_m = '1;
      end
      default: ;
    endcase
  end

  assign misalign = |(ofs & align_m);
  assign wdata    = misalign ? '0 : (payload << {ofs, 3'b000});
  assign be       = misalign ? '0 : (base_be << ofs);
endmodule

// File: rtl/lsf_out_stage.sv
module lsf_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [W-1:0] data_in,
  output logic         valid_out,
  output logic [W-1:0] data_out
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= valid_in;
          if (valid_in) d_q <= data_in;
        end
      end
      assign valid_out = v_q;
      assign data_out  = d_q;
    end else begin : g_comb
      assign valid_out = valid_in;
      assign data_out  = data_in;
    end
  endgenerate
endmodule

// File: rtl/lsf_formatter.sv
module lsf_formatter
  import lsf_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int BUS_W   = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = BUS_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [2:0]         acc_kind,
  input  logic [OFS_W-1:0]   addr_lo,
  input  logic [BUS_W-1:0]   mem_rdata,
  input  logic [REG_W-1:0]   reg_lo,
  input  logic [REG_W-1:0]   reg_hi,
  output logic               out_valid,
  output logic [REG_W-1:0]   load_lo,
  output logic [REG_W-1:0]   load_hi,
  output logic [BUS_W-1:0]   mem_wdata,
  output logic [LANES-1:0]   mem_be,
  output logic               misalign
);
  localparam int PACK_W = 2 * REG_W + BUS_W + LANES + 1;

  acc_kind_e          kind_e;
  logic [REG_W-1:0]   ld_lo_c, ld_hi_c;
  logic [BUS_W-1:0]   wdata_c;
  logic [LANES-1:0]   be_c;
  logic               mis_c;
  logic [PACK_W-1:0]  pack_in, pack_out;

  assign kind_e = acc_kind_e'(acc_kind);

  lsf_load_fmt #(.REG_W(REG_W), .BUS_W(BUS_W)) u_load (
    .kind  (kind_e),
    .ofs   (addr_lo),
    .rdata (mem_rdata),
    .ld_lo (ld_lo_c),
    .ld_hi (ld_hi_c)
  );

  lsf_store_fmt #(.REG_W(REG_W), .BUS_W(BUS_W)) u_store (
    .kind     (kind_e),
    .ofs      (addr_lo),
    .reg_lo   (reg_lo),
    .reg_hi   (reg_hi),
    .wdata    (wdata_c),
    .be       (be_c),
    .misalign (mis_c)
  );

  assign pack_in = {ld_lo_c, ld_hi_c, wdata_c, be_c, mis_c};

  lsf_out_stage #(.W(PACK_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (acc_valid),
    .data_in   (pack_in),
    .valid_out (out_valid),
    .data_out  (pack_out)
  );

  assign {load_lo, load_hi, mem_wdata, mem_be, misalign} = pack_out;

  generate
    if (REG_OUT) begin : g_chk
      AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) // R11
        acc_valid |=> out_valid);
      AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst) // R11
        !acc_valid |=> !out_valid);
      AST_Q_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst) // R3
        (acc_valid && kind_e == ACC_QHALF) |=> (load_lo[15:0] == 16'h0));
      AST_HI_ONLY_PAIR: assert property (@(posedge clk) disable iff (rst) // R4
        (acc_valid && kind_e != ACC_DWORD) |=> (load_hi == '0));
      AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (rst) // R9
        (acc_valid && kind_e == ACC_WORD && addr_lo[1:0] != 2'b00)
        |=> (misalign && mem_be == '0));
      AST_HALF_BE_COUNT: assert property (@(posedge clk) disable iff (rst) // R8
        (acc_valid && kind_e == ACC_SHALF && !addr_lo[0])
        |=> ($countones(mem_be) == 2));
      AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst) // R10
        (acc_valid && kind_e == ACC_NONE) |=> (mem_be == '0 && !misalign));
    end
  endgenerate
endmodule

// File: tb/test_lsf_formatter.sv
module test_lsf_formatter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_kind = 3'd0;
  logic [2:0]  addr_lo = 3'd0;
  logic [63:0] mem_rdata = '0;
  logic [31:0] reg_lo = '0, reg_hi = '0;
  logic        out_valid;
  logic [31:0] load_lo, load_hi;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        misalign;

  always #5 clk = ~clk;

  lsf_formatter i_lsf_formatter (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .addr_lo(addr_lo), .mem_rdata(mem_rdata), .reg_lo(reg_lo), .reg_hi(reg_hi),
    .out_valid(out_valid), .load_lo(load_lo), .load_hi(load_hi),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .misalign(misalign)
  );

  typedef struct {
    logic [2:0]  kind;
    logic        mis;
    logic [31:0] lo, hi;
    logic [63:0] wd;
    logic [7:0]  be;
    int          due;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string lo_tag(input logic [2:0] k);
    case (k)
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3: return "R2";
      3'd4:       return "R3";
      3'd7:       return "R10";
      default:    return "R4";
    endcase
  endfunction

  function automatic string wd_tag(input logic [2:0] k);
    case (k)
      3'd4:    return "R6";
      3'd6:    return "R7";
      3'd7:    return "R10";
      default: return "R5";
    endcase
  endfunction

  // Driver: apply one access and push what the requirements predict.
  task automatic send(input logic [2:0] k, input logic [2:0] a,
                      input logic [63:0] rd, input logic [31:0] rl,
                      input logic [31:0] rh);
    exp_t e;
    int n, ai;
    logic [2:0]  am;
    logic [63:0] src;
    @(negedge clk);
    ai = int'(a);
    e.kind = k; e.lo = '0; e.hi = '0; e.wd = '0; e.be = '0;
    case (k)
      3'd0, 3'd1: begin n = 1; am = 3'd0; src = {56'h0, rl[7:0]}; end
      3'd2, 3'd3: begin n = 2; am = 3'd1; src = {48'h0, rl[15:0]}; end
      3'd4:       begin n = 2; am = 3'd1; src = {48'h0, rl[31:16]}; end
      3'd5:       begin n = 4; am = 3'd3; src = {32'h0, rl}; end
      3'd6:       begin n = 8; am = 3'd7; src = {rh, rl}; end
      default:    begin n = 0; am = 3'd0; src = '0; end
    endcase
    e.mis = ((a & am) != 3'd0);
    if (!e.mis) begin
      for (int i = 0; i < 8; i++)
        if (i >= ai && i < ai + n) begin
          e.wd[8*i +: 8] = src[8*(i-ai) +: 8];
          e.be[i] = 1'b1;
        end
      case (k)
        3'd0: e.lo = {{24{rd[8*ai+7]}}, rd[8*ai +: 8]};
        3'd1: e.lo = {24'h0, rd[8*ai +: 8]};
        3'd2: e.lo = {{16{rd[8*ai+15]}}, rd[8*ai +: 16]};
        3'd3: e.lo = {16'h0, rd[8*ai +: 16]};
        3'd4: e.lo = {rd[8*ai +: 16], 16'h0};
        3'd5: e.lo = rd[8*ai +: 32];
        3'd6: begin e.lo = rd[31:0]; e.hi = rd[63:32]; end
        default: ;
      endcase
    end
    e.due = cyc + 1;
    sb.push_back(e);
    acc_valid = 1'b1; acc_kind = k; addr_lo = a;
    mem_rdata = rd; reg_lo = rl; reg_hi = rh;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    mem_rdata = '0; reg_lo = '0; reg_hi = '0;
  endtask

  // Monitor: compare results against the scoreboard head on falling edges.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk("R11", "out_valid with nothing pending", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R11", "result cycle", 64'(cyc), 64'(e.due));
          chk("R9", "misalign flag", {63'h0, misalign}, {63'h0, e.mis});
          if (e.mis) begin
            chk("R9", "enables on misaligned", {56'h0, mem_be}, 64'h0);
            chk("R9", "write data on misaligned", mem_wdata, 64'h0);
          end else begin
            chk(lo_tag(e.kind), "load_lo", {32'h0, load_lo}, {32'h0, e.lo});
            chk(e.kind == 3'd7 ? "R10" : "R4", "load_hi",
                {32'h0, load_hi}, {32'h0, e.hi});
            chk(wd_tag(e.kind), "mem_wdata", mem_wdata, e.wd);
            chk(e.kind == 3'd7 ? "R10" : "R8", "mem_be",
                {56'h0, mem_be}, {56'h0, e.be});
          end
        end
      end else if (sb.size() != 0 && sb[0].due <= cyc) begin
        chk("R11", "missing out_valid", 64'd0, 64'd1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11", "out_valid in reset", {63'h0, out_valid}, 64'd0);
    chk("R11", "mem_be in reset", {56'h0, mem_be}, 64'd0);
    chk("R11", "misalign in reset", {63'h0, misalign}, 64'd0);
    rst = 1'b0;
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 8; a++)
        for (int p = 0; p < 3; p++) begin
          logic [63:0] rd;
          logic [31:0] rl, rh;
          rd = {$urandom, $urandom};
          rl = $urandom; rh = $urandom;
          if (p == 1) rd = rd | 64'h8080_8080_8080_8080;
          if (p == 2) begin rd = rd & 64'h7F7F_7F7F_7F7F_7F7F; rl = 32'h8001_FF7E; end
          send(3'(k), 3'(a), rd, rl, rh);
          if (((k * 8 + a) * 3 + p) % 5 == 4) idle();
        end
    idle();
    repeat (4) @(negedge clk);
    chk("R11", "entries left unmatched", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule